// File: doc/BRIEF.md
# Multi-Polynomial CRC Calculator

This block computes a running CRC over data that a processor writes into it one register access at a time. A control register selects one of four generator polynomials (8, 16 or 32 bits wide) and how many bytes of each write are consumed. It also sets two independent conditioning options on the incoming data: a mirror of the bits inside each byte, and a ones' complement. Two further independent options act on the value read back: a mirror of the whole 32-bit word, and a ones' complement. The output options shape only what is read. They never change the running value.

A seed register holds the starting value. Software writes the seed, then sets the self-clearing restart bit in the control word. That loads the seed into the running CRC and keeps every other control field. Software then streams data through the data register and reads the checksum register. Each accepted write is folded in on the next clock edge. The update is non-reflected and shifts most significant bit first. Reflected standard CRCs come from combining input byte mirroring with output word mirroring.

Top module: `crc_engine`

## Requirements
- R1: Control bit 0 is the enable. While it is 0, writes to the data register leave the running CRC, and therefore the checksum, unchanged.
- R2: Writing a control word with bit 1 set loads the seed, masked to the polynomial width, into the running CRC. All other control fields take the written value as usual. Bit 1 reads back as 1 for RST_HOLD clock cycles and then clears by itself. Data writes during that time are ignored.
- R3: Control bits 31:30 select the polynomial: 0 = 0x1021 (16 bit), 1 = 0x07 (8 bit), 2 = 0x8005 (16 bit), 3 = 0x04C11DB7 (32 bit). The update is non-reflected, most significant bit first. Only the low width bits of the state are significant; the higher checksum bits read 0 before output options.
- R4: Control bits 29:28 give the number of bytes consumed per data write: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. The least significant bytes of the word are used, and the most significant used byte is processed first.
- R5: With control bit 24 set, the bit order inside each byte of the written word is mirrored before the update. For example, 0xAABBCCDD is processed as 0x55DD33BB.
- R6: With control bit 26 set, the written word is ones'-complemented before the update, independently of bit 24.
- R7: With control bit 25 set, the checksum read is the full 32-bit mirror of the masked state. Changing this bit never alters the running CRC.
- R8: With control bit 27 set, the checksum read is ones'-complemented after any mirroring, independently of bit 25.
- R9: Register word addresses: 0 = control, 1 = seed (read-write), 2 = data (write only, reads 0), 3 = checksum (read only; writes are ignored). After reset, control, seed and checksum read 0.
- R10: An accepted data write is reflected in the checksum at the clock edge that accepts it, with one cycle per write regardless of its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Word address of the write |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 2 | Word address of the read |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |

## Verification
A corrupted running CRC shows up on the checksum register right after the write that caused it, at the next clock edge. Once the state is wrong, every later checksum is wrong too, until software restarts the engine. This makes a single wrong fold permanent and easy to see. Faults in the output options show only at the read mux and change no state. Toggling those options over a fixed state therefore separates them from faults in the update path. A wrong restart counter shows up as the wrong bit 1 value in the control readback, or as a data write accepted or dropped during the restart window.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_BYTES = WORD_W / 8;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_SEED = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_DATA = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_SUM  = 2'd3;

  typedef enum logic [1:0] {
    POLY_CCITT = 2'd0,
    POLY_C8    = 2'd1,
    POLY_C16   = 2'd2,
    POLY_C32   = 2'd3
  } poly_sel_e;

  typedef struct packed {
    poly_sel_e  mode;
    logic [1:0] wlen;
    logic       out_com;
    logic       in_com;
    logic       out_rvs;
    logic       in_rvs;
    logic       enable;
  } crc_cfg_t;

  function automatic logic [WORD_W-1:0] poly_of(poly_sel_e m);
    case (m)
      POLY_CCITT: poly_of = 32'h0000_1021;
      POLY_C8:    poly_of = 32'h0000_0007;
      POLY_C16:   poly_of = 32'h0000_8005;
      default:    poly_of = 32'h04C1_1DB7;
    endcase
  endfunction

  function automatic int unsigned width_of(poly_sel_e m);
    case (m)
      POLY_C8:  width_of = 8;
      POLY_C32: width_of = 32;
      default:  width_of = 16;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] width_mask(poly_sel_e m);
    logic [WORD_W:0] one_past;
    one_past   = (WORD_W+1)'(1) << width_of(m);
    width_mask = WORD_W'(one_past - 1'b1);
  endfunction

  function automatic int unsigned bytes_of(logic [1:0] wl);
    case (wl)
      2'd0:    bytes_of = 1;
      2'd1:    bytes_of = 2;
      default: bytes_of = 4;
    endcase
  endfunction

  // one byte folded in, most significant bit first, state in low bits
  function automatic logic [WORD_W-1:0] crc_byte_step(logic [WORD_W-1:0] st,
                                                      logic [7:0] b,
                                                      poly_sel_e m);
    logic [WORD_W-1:0] s;
    logic [WORD_W-1:0] msk;
    logic              fb;
    int unsigned       top;
    msk = width_mask(m);
    top = width_of(m) - 1;
    s   = st & msk;
    for (int i = 7; i >= 0; i--) begin
      fb = s[top] ^ b[i];
      s  = (s << 1) & msk;
      if (fb) s = s ^ poly_of(m);
    end
    crc_byte_step = s;
  endfunction

  function automatic logic [WORD_W-1:0] crc_word_update(logic [WORD_W-1:0] st,
                                                        logic [WORD_W-1:0] d,
                                                        logic [1:0] wl,
                                                        poly_sel_e m);
    logic [WORD_W-1:0] s;
    int unsigned       nb;
    s  = st;
    nb = bytes_of(wl);
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (k < nb) s = crc_byte_step(s, d[8*(nb-1-k) +: 8], m);
    end
    crc_word_update = s;
  endfunction

endpackage

// File: rtl/crc_ctrl_regs.sv
module crc_ctrl_regs
  import crc_pkg::*;
#(
  parameter int RST_HOLD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              seed_wr,
  input  logic [WORD_W-1:0] wr_data,
  output crc_cfg_t          cfg_q,
  output logic [WORD_W-1:0] seed_q,
  output logic              rst_busy
);

  localparam int CNT_W = (RST_HOLD < 2) ? 1 : $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0] hold_cnt;
  logic             unused_bits;

  assign unused_bits = ^wr_data[23:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      seed_q   <= '0;
      rst_busy <= 1'b0;
      hold_cnt <= '0;
    end else begin
      if (ctl_wr) begin
        cfg_q.mode    <= poly_sel_e'(wr_data[31:30]);
        cfg_q.wlen    <= wr_data[29:28];
        cfg_q.out_com <= wr_data[27];
        cfg_q.in_com  <= wr_data[26];
        cfg_q.out_rvs <= wr_data[25];
        cfg_q.in_rvs  <= wr_data[24];
        cfg_q.enable  <= wr_data[0];
      end
      if (seed_wr) seed_q <= wr_data;
      if (ctl_wr && wr_data[1]) begin
        rst_busy <= 1'b1;
        hold_cnt <= CNT_W'(RST_HOLD - 1);
      end else if (rst_busy) begin
        if (hold_cnt == '0) rst_busy <= 1'b0;
        else                hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/crc_in_cond.sv
module crc_in_cond
  import crc_pkg::*;
(
  input  logic [WORD_W-1:0] raw,
  input  logic              in_rvs,
  input  logic              in_com,
  output logic [WORD_W-1:0] cooked
);

  logic [WORD_W-1:0] mirrored;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign mirrored[8*b + i] = raw[8*b + 7 - i];
    end
  end

  assign cooked = (in_rvs ? mirrored : raw) ^ {WORD_W{in_com}};

endmodule

// File: rtl/crc_core.sv
module crc_core
  import crc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_seed,
  input  logic [WORD_W-1:0] seed,
  input  logic              fire,
  input  logic [WORD_W-1:0] din,
  input  logic [1:0]        wlen,
  input  poly_sel_e         mode,
  output logic [WORD_W-1:0] state_q,
  output logic [WORD_W-1:0] next_state
);

  assign next_state = crc_word_update(state_q, din, wlen, mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= '0;
    else if (load_seed) state_q <= seed & width_mask(mode);
    else if (fire)      state_q <= next_state;
  end

endmodule

// File: rtl/crc_out_cond.sv
module crc_out_cond
  import crc_pkg::*;
(
  input  logic [WORD_W-1:0] state,
  input  poly_sel_e         mode,
  input  logic              out_rvs,
  input  logic              out_com,
  output logic [WORD_W-1:0] checksum
);

  logic [WORD_W-1:0] masked;
  logic [WORD_W-1:0] mirrored;

  assign masked = state & width_mask(mode);

  for (genvar i = 0; i < WORD_W; i++) begin : g_mir
    assign mirrored[i] = masked[WORD_W - 1 - i];
  end

  assign checksum = (out_rvs ? mirrored : masked) ^ {WORD_W{out_com}};

endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int RST_HOLD = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  input  logic [1:0]  bus_raddr,
  output logic [31:0] bus_rdata
);

  crc_cfg_t          cfg_q;
  logic [WORD_W-1:0] seed_q;
  logic              rst_busy;
  logic              ctl_wr;
  logic              seed_wr;
  logic              data_wr;
  logic              data_fire;
  logic              ctl_en;
  logic [WORD_W-1:0] cooked;
  logic [WORD_W-1:0] crc_state;
  logic [WORD_W-1:0] next_state;
  logic [WORD_W-1:0] seed_masked;
  logic [WORD_W-1:0] checksum;
  logic [7:0]        cfg_bits;

  assign ctl_wr      = bus_wr && (bus_addr == ADR_CTL);
  assign seed_wr     = bus_wr && (bus_addr == ADR_SEED);
  assign data_wr     = bus_wr && (bus_addr == ADR_DATA);
  assign ctl_en      = cfg_q.enable;
  assign data_fire   = data_wr && ctl_en && !rst_busy;
  assign seed_masked = seed_q & width_mask(cfg_q.mode);
  assign cfg_bits    = cfg_q;

  crc_ctrl_regs #(.RST_HOLD(RST_HOLD)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .seed_wr  (seed_wr),
    .wr_data  (bus_wdata),
    .cfg_q    (cfg_q),
    .seed_q   (seed_q),
    .rst_busy (rst_busy)
  );

  crc_in_cond u_in (
    .raw    (bus_wdata),
    .in_rvs (cfg_q.in_rvs),
    .in_com (cfg_q.in_com),
    .cooked (cooked)
  );

  crc_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_seed  (rst_busy),
    .seed       (seed_q),
    .fire       (data_fire),
    .din        (cooked),
    .wlen       (cfg_q.wlen),
    .mode       (cfg_q.mode),
    .state_q    (crc_state),
    .next_state (next_state)
  );

  crc_out_cond u_out (
    .state    (crc_state),
    .mode     (cfg_q.mode),
    .out_rvs  (cfg_q.out_rvs),
    .out_com  (cfg_q.out_com),
    .checksum (checksum)
  );

  always_comb begin
    case (bus_raddr)
      ADR_CTL:  bus_rdata = {cfg_q.mode, cfg_q.wlen, cfg_q.out_com, cfg_q.in_com,
                             cfg_q.out_rvs, cfg_q.in_rvs, 22'd0, rst_busy, cfg_q.enable};
      ADR_SEED: bus_rdata = seed_q;
      ADR_SUM:  bus_rdata = checksum;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk #(
  parameter int RST_HOLD = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_en,
  input logic        rst_busy,
  input logic        ctl_wr,
  input logic        wr_rst_bit,
  input logic        data_fire,
  input logic [31:0] crc_state,
  input logic [31:0] seed_masked,
  input logic [7:0]  cfg_bits
);

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    busy_run <= 0;
    else if (ctl_wr && wr_rst_bit) busy_run <= 0;
    else if (rst_busy)             busy_run <= busy_run + 1;
    else                           busy_run <= 0;
  end

  // R2: restart flag never outlasts its hold window
  always_ff @(posedge clk) begin
    if (rst_n) a_r2_busy_bounded: assert (busy_run <= RST_HOLD);
  end

  // R1: disabled engine keeps its state
  a_r1_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !rst_busy) |=> $stable(crc_state));

  // R2: a restart cycle loads the masked seed
  a_r2_seed_reload: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> (crc_state == $past(seed_masked)));

  // R2: restart leaves configuration alone
  a_r2_cfg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && !ctl_wr) |=> $stable(cfg_bits));

  // R7: nothing but an accepted write or a restart moves the state
  a_r7_state_only_by_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_fire && !rst_busy) |=> $stable(crc_state));

endmodule

bind crc_engine crc_engine_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctl_en      (ctl_en),
  .rst_busy    (rst_busy),
  .ctl_wr      (ctl_wr),
  .wr_rst_bit  (bus_wdata[1]),
  .data_fire   (data_fire),
  .crc_state   (crc_state),
  .seed_masked (seed_masked),
  .cfg_bits    (cfg_bits)
);

// File: tb/tb_crc_engine.sv
`timescale 1ns/1ps
module tb_crc_engine;

  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [1:0]  bus_raddr = 2'd0;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic [31:0] m_state = 0, m_seed = 0;
  logic        m_en = 0, m_irv = 0, m_orv = 0, m_icm = 0, m_ocm = 0;
  logic [1:0]  m_wl = 0, m_md = 0;

  crc_engine #(.RST_HOLD(HOLD)) dut (.*);

  always #2.5 clk = ~clk;

  function automatic int tb_width(logic [1:0] md);
    return (md == 2'd1) ? 8 : (md == 2'd3) ? 32 : 16;
  endfunction

  function automatic logic [31:0] tb_poly(logic [1:0] md);
    logic [31:0] p [4] = '{32'h1021, 32'h07, 32'h8005, 32'h04C11DB7};
    return p[md];
  endfunction

  function automatic logic [31:0] tb_mask(logic [1:0] md);
    logic [31:0] m = 0;
    for (int i = 0; i < tb_width(md); i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] tb_byte_mirror(logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = d[(i/8)*8 + 7 - (i%8)];
    return r;
  endfunction

  function automatic logic [31:0] tb_word_mirror(logic [31:0] d);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = d[31-i];
    return r;
  endfunction

  // serial bit stream form of the update
  function automatic logic [31:0] tb_fold(logic [31:0] st, logic [31:0] d,
                                          logic [1:0] wl, logic [1:0] md);
    int nbits = (wl == 2'd0) ? 8 : (wl == 2'd1) ? 16 : 32;
    int w = tb_width(md);
    logic [31:0] s = st & tb_mask(md);
    for (int i = nbits - 1; i >= 0; i--) begin
      logic top = s[w-1];
      s = (s << 1) & tb_mask(md);
      if (top != d[i]) s = s ^ tb_poly(md);
    end
    return s;
  endfunction

  function automatic logic [31:0] tb_readout();
    logic [31:0] v = m_state & tb_mask(m_md);
    if (m_orv) v = tb_word_mirror(v);
    if (m_ocm) v = ~v;
    return v;
  endfunction

  function automatic logic [31:0] mk_ctl(logic en, logic rs, logic irv, logic orv,
                                         logic icm, logic ocm, logic [1:0] wl,
                                         logic [1:0] md);
    return {md, wl, ocm, icm, orv, irv, 22'd0, rs, en};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_cfg(logic en, logic irv, logic orv, logic icm, logic ocm,
                         logic [1:0] wl, logic [1:0] md, logic restart);
    m_en = en; m_irv = irv; m_orv = orv; m_icm = icm; m_ocm = ocm; m_wl = wl; m_md = md;
    bus_write(2'd0, mk_ctl(en, restart, irv, orv, icm, ocm, wl, md));
    if (restart) begin
      m_state = m_seed & tb_mask(md);
      repeat (HOLD) @(negedge clk);
    end
  endtask

  task automatic set_seed(logic [31:0] s);
    m_seed = s;
    bus_write(2'd1, s);
  endtask

  task automatic feed(logic [31:0] d);
    logic [31:0] c = d;
    if (m_irv) c = tb_byte_mirror(c);
    if (m_icm) c = ~c;
    if (m_en) m_state = tb_fold(m_state, c, m_wl, m_md);
    bus_write(2'd2, d);
  endtask

  task automatic feed_check_string(logic [1:0] wl);
    logic [7:0] s [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    if (wl == 2'd0) begin
      for (int i = 0; i < 9; i++) feed({24'd0, s[i]});
    end else if (wl == 2'd1) begin
      for (int i = 0; i < 8; i += 2) feed({16'd0, s[i], s[i+1]});
      set_cfg(m_en, m_irv, m_orv, m_icm, m_ocm, 2'd0, m_md, 1'b0);
      feed({24'd0, s[8]});
    end else begin
      feed({s[0], s[1], s[2], s[3]});
      feed({s[4], s[5], s[6], s[7]});
      set_cfg(m_en, m_irv, m_orv, m_icm, m_ocm, 2'd0, m_md, 1'b0);
      feed({24'd0, s[8]});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rv, rv2;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset values
    bus_read(2'd0, rv); check("R9 ctl reset", rv, 32'd0);
    bus_read(2'd1, rv); check("R9 seed reset", rv, 32'd0);
    bus_read(2'd3, rv); check("R9 sum reset", rv, 32'd0);

    // R3 R5 R7 R8: reflected CRC-32 check value
    set_seed(32'hFFFF_FFFF);
    set_cfg(1, 1, 1, 0, 1, 2'd0, 2'd3, 1);
    feed_check_string(2'd0);
    bus_read(2'd3, rv); check("R3 R5 R7 R8 reflected crc32", rv, 32'hCBF4_3926);

    // R3: plain non-reflected CRC-32
    set_cfg(1, 0, 0, 0, 0, 2'd0, 2'd3, 1);
    feed_check_string(2'd0);
    bus_read(2'd3, rv); check("R3 crc32 msb-first", rv, 32'h0376_E6E7);

    // R4 R10: same result with 32-bit and 16-bit writes
    set_cfg(1, 0, 0, 0, 0, 2'd2, 2'd3, 1);
    feed_check_string(2'd2);
    bus_read(2'd3, rv); check("R4 R10 word writes", rv, 32'h0376_E6E7);
    set_cfg(1, 0, 0, 0, 0, 2'd1, 2'd3, 1);
    feed_check_string(2'd1);
    bus_read(2'd3, rv); check("R4 halfword writes", rv, 32'h0376_E6E7);

    // R3: the narrower polynomials
    set_cfg(1, 0, 0, 0, 0, 2'd0, 2'd0, 1);
    feed_check_string(2'd0);
    bus_read(2'd3, rv); check("R3 ccitt seed ffff", rv, 32'h0000_29B1);
    set_seed(32'd0);
    set_cfg(1, 0, 0, 0, 0, 2'd0, 2'd1, 1);
    feed_check_string(2'd0);
    bus_read(2'd3, rv); check("R3 crc8", rv, 32'h0000_00F4);
    set_cfg(1, 0, 0, 0, 0, 2'd0, 2'd2, 1);
    feed_check_string(2'd0);
    bus_read(2'd3, rv); check("R3 crc16", rv, 32'h0000_FEE8);

    // R5: per-byte mirror example, via the model
    check("R5 mirror example", tb_byte_mirror(32'hAABBCCDD), 32'h55DD33BB);
    set_cfg(1, 1, 0, 0, 0, 2'd2, 2'd3, 1);
    feed(32'hAABBCCDD);
    bus_read(2'd3, rv); check("R5 byte mirrored input", rv, tb_readout());

    // R6: input complement
    set_cfg(1, 0, 0, 1, 0, 2'd2, 2'd3, 1);
    feed(32'h1234_5678);
    bus_read(2'd3, rv); check("R6 input complement", rv, tb_readout());

    // R7 R8: output options over a fixed state
    bus_read(2'd3, rv2);
    set_cfg(1, 0, 1, 1, 0, 2'd2, 2'd3, 0);
    bus_read(2'd3, rv); check("R7 word mirror readout", rv, tb_word_mirror(rv2));
    set_cfg(1, 0, 1, 1, 1, 2'd2, 2'd3, 0);
    bus_read(2'd3, rv); check("R8 complement after mirror", rv, ~tb_word_mirror(rv2));
    set_cfg(1, 0, 0, 1, 0, 2'd2, 2'd3, 0);
    bus_read(2'd3, rv); check("R7 state untouched", rv, rv2);

    // R1: disabled
    set_cfg(0, 0, 0, 0, 0, 2'd2, 2'd3, 0);
    feed(32'hDEAD_BEEF);
    bus_read(2'd3, rv); check("R1 disabled write ignored", rv, rv2);

    // R9: writes to checksum ignored, data reads 0
    bus_write(2'd3, 32'h1111_2222);
    bus_read(2'd3, rv); check("R9 checksum read-only", rv, rv2);
    bus_read(2'd2, rv); check("R9 data reads zero", rv, 32'd0);

    // R2: restart flag, preserved fields, ignored data while busy
    set_seed(32'hCAFE_F00D);
    m_en = 1; m_icm = 0; m_wl = 2'd2; m_md = 2'd3;
    bus_write(2'd0, mk_ctl(1, 1, 0, 0, 0, 0, 2'd2, 2'd3));
    bus_read(2'd0, rv); check("R2 flag set", rv, mk_ctl(1, 1, 0, 0, 0, 0, 2'd2, 2'd3));
    bus_write(2'd2, 32'h0BAD_0BAD);
    repeat (HOLD - 1) @(negedge clk);
    bus_read(2'd0, rv); check("R2 flag self-clears", rv, mk_ctl(1, 0, 0, 0, 0, 0, 2'd2, 2'd3));
    bus_read(2'd3, rv); check("R2 seed loaded, busy write dropped", rv, 32'hCAFE_F00D);
    m_state = 32'hCAFE_F00D;

    // R2 R3: seed masked for narrow width
    set_cfg(1, 0, 0, 0, 0, 2'd0, 2'd1, 1);
    bus_read(2'd3, rv); check("R3 narrow seed masked", rv, 32'h0000_000D);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom % 12;
      logic [31:0] r = $urandom;
      if (op == 0)
        set_cfg(($urandom % 4) != 0, r[24], r[25], r[26], r[27], r[29:28], r[31:30], 1'b0);
      else if (op == 1) set_seed(r);
      else if (op == 2)
        set_cfg(1, m_irv, m_orv, m_icm, m_ocm, m_wl, m_md, 1'b1);
      else feed(r);
      bus_read(2'd3, rv); check("R1 R3 R4 R5 R6 R7 R8 R10 random", rv, tb_readout());
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule